// File: doc/BRIEF.md
# Memory Bus Wiring Test Engine

This block is a hardware sequencer that proves the wiring between a chip and an external memory of 32-bit words before anything is stored there. After a start pulse it first sends a single set bit across every data line, using one address. It then runs a three-step check of the address lines over the power-of-two byte offsets inside the memory size: lines stuck at one, lines stuck at zero, and lines shorted together.

The engine is the only master on a simple memory port. It raises a request with a write enable, a byte address and write data, and holds it until the port accepts it. A read is complete only when the memory returns a word with its read-valid strobe. Only one transaction is in flight at a time. The first mismatch stops the run. At the end, a one-cycle done pulse reports pass or fail and the address where the run failed.

Top module: `mbt_engine`

## Requirements
- R1: Out of reset, busy, done and fail are low, fail_addr is zero and no memory request is raised; no request is raised while busy is low.
- R2: The data phase comes first. It writes the word 1<<i to base_addr and reads it back, for i = 0 up to 31 in rising order, so the first accepted request is a write of 0x00000001 to base_addr.
- R3: A data-phase read that differs from the value just written ends the run with fail high and fail_addr equal to base_addr.
- R4: The address phase visits byte offsets 4, 8, 16 and so on, and keeps going only while (offset AND (mem_size − 1)) is nonzero. It uses the pattern 0xAAAAAAAA and its complement 0x55555555. With mem_size = 4 no offset is visited.
- R5: The pattern is written at every visited offset, and then the complement at offset 0. Each visited offset is then read back. Any word other than the pattern fails at base_addr + offset.
- R6: The pattern is then written back to offset 0. For each visited test offset, the engine writes the complement there and checks that base_addr still reads the pattern (fail at base_addr otherwise). It then checks that every other visited offset still reads the pattern (fail at base_addr + offset), without reading the test offset itself. Last, it writes the pattern back to the test offset.
- R7: A passing run issues exactly 64 + 2N + 2 + N(N + 2) accepted requests, where N is the number of visited offsets (206 when mem_size = 4096).
- R8: A request stays raised, with its address, data and write enable steady, until mem_req_ready. No new request is raised while a read awaits mem_rvalid.
- R9: done is high for exactly one cycle, with busy low. A passing run reports fail low and fail_addr zero.
- R10: fail and fail_addr hold their values until the next accepted start, which clears them. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| base_addr | input | AW | Byte address of the memory's first word |
| mem_size | input | AW+1 | Memory size in bytes, a power of two |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run found a fault |
| fail_addr | output | AW | Address where the run failed, zero on pass |
| mem_req_valid | output | 1 | Memory request raised |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data is valid |

## Verification
A memory model with backpressure and a two-cycle read delay is run fault-free at two sizes, and at a size small enough that no offset is visited. Each run's request count confirms the offset loop and the skip rule. Separate runs inject a data line stuck low, an address line stuck high, an address line stuck low and two address lines shorted as a wired OR. Each fault is caught by a different phase and gives its own failure address. A stuck-high line above the programmed size must pass, which shows that mem_size limits the walk.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    localparam logic [31:0] PAT_WORD  = 32'hAAAA_AAAA;
    localparam logic [31:0] ANTI_WORD = 32'h5555_5555;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DWR,
        S_DRD,
        S_FILL,
        S_ANTI0,
        S_CHKH,
        S_REST0,
        S_TWR,
        S_TBASE,
        S_TCHK,
        S_TREST
    } seq_state_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_REQ,
        P_WAIT
    } port_state_t;

    // Offset still inside the memory window
    function automatic logic off_live(input logic [32:0] off, input logic [32:0] mask);
        return (off & mask) != 33'd0;
    endfunction

endpackage

// File: rtl/mbt_memport.sv
module mbt_memport
    import mbt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_we,
    input  logic [AW-1:0] go_addr,
    input  logic [31:0]   go_wdata,
    output logic          op_done,
    output logic [31:0]   op_rdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rvalid
);

    port_state_t   st;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [31:0]   wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= P_IDLE;
            op_done  <= 1'b0;
            op_rdata <= '0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wd_q     <= '0;
        end else begin
            op_done <= 1'b0;
            case (st)
                P_IDLE: if (go) begin
                    we_q   <= go_we;
                    addr_q <= go_addr;
                    wd_q   <= go_wdata;
                    st     <= P_REQ;
                end
                P_REQ: if (mem_req_ready) begin
                    if (we_q) begin
                        op_done <= 1'b1;
                        st      <= P_IDLE;
                    end else begin
                        st <= P_WAIT;
                    end
                end
                P_WAIT: if (mem_rvalid) begin
                    op_rdata <= mem_rdata;
                    op_done  <= 1'b1;
                    st       <= P_IDLE;
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (st == P_REQ);
    assign mem_we        = we_q;
    assign mem_addr      = addr_q;
    assign mem_wdata     = wd_q;

endmodule

// File: rtl/mbt_seq.sv
module mbt_seq
    import mbt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW:0]   mem_size,
    input  logic          op_done,
    input  logic [31:0]   op_rdata,
    output logic          go,
    output logic          go_we,
    output logic [AW-1:0] go_addr,
    output logic [31:0]   go_wdata,
    output logic          busy,
    output logic          launch,
    output logic          fin_evt,
    output logic          fin_bad,
    output logic [AW-1:0] fin_where
);

    localparam logic [AW:0] FIRST_OFF = (AW+1)'(4);

    seq_state_t  st, st_n;
    logic [31:0] walk, walk_n;
    logic [AW:0] off, off_n, toff, toff_n;
    logic        pending, need;
    logic        off_ok, toff_ok;
    logic [AW:0] mask;

    assign mask    = mem_size - 1'b1;
    assign off_ok  = off_live(33'(off), 33'(mask));
    assign toff_ok = off_live(33'(toff), 33'(mask));
    assign busy    = (st != S_IDLE);
    assign launch  = (st == S_IDLE) && start;
    assign go      = need && !pending;

    always_comb begin
        st_n      = st;
        walk_n    = walk;
        off_n     = off;
        toff_n    = toff;
        need      = 1'b0;
        go_we     = 1'b0;
        go_addr   = base_addr;
        go_wdata  = '0;
        fin_evt   = 1'b0;
        fin_bad   = 1'b0;
        fin_where = '0;
        case (st)
            S_IDLE: if (start) begin
                st_n   = S_DWR;
                walk_n = 32'd1;
            end
            S_DWR: begin
                need     = 1'b1;
                go_we    = 1'b1;
                go_wdata = walk;
                if (op_done) st_n = S_DRD;
            end
            S_DRD: begin
                need = 1'b1;
                if (op_done) begin
                    if (op_rdata != walk) begin
                        fin_evt   = 1'b1;
                        fin_bad   = 1'b1;
                        fin_where = base_addr;
                        st_n      = S_IDLE;
                    end else if (walk[31]) begin
                        st_n  = S_FILL;
                        off_n = FIRST_OFF;
                    end else begin
                        walk_n = walk << 1;
                        st_n   = S_DWR;
                    end
                end
            end
            S_FILL: begin
                if (!off_ok) begin
                    st_n = S_ANTI0;
                end else begin
                    need     = 1'b1;
                    go_we    = 1'b1;
                    go_addr  = base_addr + off[AW-1:0];
                    go_wdata = PAT_WORD;
                    if (op_done) off_n = off << 1;
                end
            end
            S_ANTI0: begin
                need     = 1'b1;
                go_we    = 1'b1;
                go_wdata = ANTI_WORD;
                if (op_done) begin
                    st_n  = S_CHKH;
                    off_n = FIRST_OFF;
                end
            end
            S_CHKH: begin
                if (!off_ok) begin
                    st_n = S_REST0;
                end else begin
                    need    = 1'b1;
                    go_addr = base_addr + off[AW-1:0];
                    if (op_done) begin
                        if (op_rdata != PAT_WORD) begin
                            fin_evt   = 1'b1;
                            fin_bad   = 1'b1;
                            fin_where = base_addr + off[AW-1:0];
                            st_n      = S_IDLE;
                        end else begin
                            off_n = off << 1;
                        end
                    end
                end
            end
            S_REST0: begin
                need     = 1'b1;
                go_we    = 1'b1;
                go_wdata = PAT_WORD;
                if (op_done) begin
                    st_n   = S_TWR;
                    toff_n = FIRST_OFF;
                end
            end
            S_TWR: begin
                if (!toff_ok) begin
                    fin_evt = 1'b1;
                    st_n    = S_IDLE;
                end else begin
                    need     = 1'b1;
                    go_we    = 1'b1;
                    go_addr  = base_addr + toff[AW-1:0];
                    go_wdata = ANTI_WORD;
                    if (op_done) st_n = S_TBASE;
                end
            end
            S_TBASE: begin
                need = 1'b1;
                if (op_done) begin
                    if (op_rdata != PAT_WORD) begin
                        fin_evt   = 1'b1;
                        fin_bad   = 1'b1;
                        fin_where = base_addr;
                        st_n      = S_IDLE;
                    end else begin
                        st_n  = S_TCHK;
                        off_n = FIRST_OFF;
                    end
                end
            end
            S_TCHK: begin
                if (!off_ok) begin
                    st_n = S_TREST;
                end else if (off == toff) begin
                    off_n = off << 1;
                end else begin
                    need    = 1'b1;
                    go_addr = base_addr + off[AW-1:0];
                    if (op_done) begin
                        if (op_rdata != PAT_WORD) begin
                            fin_evt   = 1'b1;
                            fin_bad   = 1'b1;
                            fin_where = base_addr + off[AW-1:0];
                            st_n      = S_IDLE;
                        end else begin
                            off_n = off << 1;
                        end
                    end
                end
            end
            S_TREST: begin
                need     = 1'b1;
                go_we    = 1'b1;
                go_addr  = base_addr + toff[AW-1:0];
                go_wdata = PAT_WORD;
                if (op_done) begin
                    toff_n = toff << 1;
                    st_n   = S_TWR;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            walk    <= '0;
            off     <= '0;
            toff    <= '0;
            pending <= 1'b0;
        end else begin
            st   <= st_n;
            walk <= walk_n;
            off  <= off_n;
            toff <= toff_n;
            if (go)
                pending <= 1'b1;
            else if (op_done)
                pending <= 1'b0;
        end
    end

endmodule

// File: rtl/mbt_result.sv
module mbt_result #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          fin_evt,
    input  logic          fin_bad,
    input  logic [AW-1:0] fin_where,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
        end else begin
            done <= fin_evt;
            if (launch) begin
                fail      <= 1'b0;
                fail_addr <= '0;
            end else if (fin_evt) begin
                fail      <= fin_bad;
                fail_addr <= fin_where;
            end
        end
    end

endmodule

// File: rtl/mbt_engine.sv
module mbt_engine
    import mbt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW:0]   mem_size,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rvalid
);

    logic          go, go_we, op_done;
    logic [AW-1:0] go_addr;
    logic [31:0]   go_wdata, op_rdata;
    logic          launch, fin_evt, fin_bad;
    logic [AW-1:0] fin_where;

    mbt_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .base_addr(base_addr), .mem_size(mem_size),
        .op_done(op_done), .op_rdata(op_rdata),
        .go(go), .go_we(go_we), .go_addr(go_addr), .go_wdata(go_wdata),
        .busy(busy), .launch(launch),
        .fin_evt(fin_evt), .fin_bad(fin_bad), .fin_where(fin_where)
    );

    mbt_memport #(.AW(AW)) u_port (
        .clk(clk), .rst(rst),
        .go(go), .go_we(go_we), .go_addr(go_addr), .go_wdata(go_wdata),
        .op_done(op_done), .op_rdata(op_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    mbt_result #(.AW(AW)) u_res (
        .clk(clk), .rst(rst),
        .launch(launch), .fin_evt(fin_evt), .fin_bad(fin_bad), .fin_where(fin_where),
        .done(done), .fail(fail), .fail_addr(fail_addr)
    );

endmodule

// File: rtl/mbt_engine_chk.sv
module mbt_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_pass_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> (fail_addr == '0));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(fail) && $stable(fail_addr)));

    assert_start_take_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind mbt_engine mbt_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_mbt_engine.sv
module tb_mbt_engine;

    localparam int AW = 16;
    localparam logic [15:0] BASE = 16'h4000;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] base_addr;
    logic [AW:0]   mem_size;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic          mem_req_valid, mem_req_ready, mem_we, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    mbt_engine #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .mem_size(mem_size),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // memory model with fault injection
    int fault_kind = 0;   // 0 none, 1 addr stuck high, 2 addr stuck low, 3 addr OR short, 4 data stuck low
    int fault_a = 0;
    int fault_b = 0;
    logic        clr_cnt = 1'b0;
    logic [31:0] mem [0:1023];
    int          n_acc, ready_cnt, rd_cnt, viol;
    logic        rd_out;
    logic [31:0] rd_hold;
    logic        first_we;
    logic [15:0] first_addr;
    logic [31:0] first_wdata;

    function automatic int map_idx(input logic [15:0] a);
        logic [15:0] d;
        int i;
        d = a - BASE;
        i = int'(d[11:2]);
        case (fault_kind)
            1: i = i | (1 << fault_a);
            2: i = i & ~(1 << fault_a);
            3: if ((((i >> fault_a) & 1) != 0) || (((i >> fault_b) & 1) != 0))
                   i = i | (1 << fault_a) | (1 << fault_b);
            default: ;
        endcase
        return i & 1023;
    endfunction

    assign mem_req_ready = (ready_cnt % 3) != 2;

    always @(posedge clk) begin
        if (rst) begin
            rd_cnt     <= 0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            rd_out     <= 1'b0;
            ready_cnt  <= 0;
            n_acc      <= 0;
            viol       <= 0;
        end else begin
            ready_cnt  <= ready_cnt + 1;
            mem_rvalid <= 1'b0;
            if (rd_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd_hold;
                rd_out     <= 1'b0;
            end
            if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
            if (mem_req_valid && rd_out) viol <= viol + 1;
            if (clr_cnt) begin
                n_acc <= 0;
                viol  <= 0;
            end else if (mem_req_valid && mem_req_ready) begin
                n_acc <= n_acc + 1;
                if (n_acc == 0) begin
                    first_we    <= mem_we;
                    first_addr  <= mem_addr;
                    first_wdata <= mem_wdata;
                end
                if (mem_we) begin
                    mem[map_idx(mem_addr)] <= mem_wdata;
                end else begin
                    rd_hold <= (fault_kind == 4) ? (mem[map_idx(mem_addr)] & ~(32'd1 << fault_a))
                                                 : mem[map_idx(mem_addr)];
                    rd_cnt  <= 2;
                    rd_out  <= 1'b1;
                end
            end
        end
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input string req, input int size, input int kind, input int fa, input int fb,
                            input bit exp_fail, input int exp_addr, input int exp_count, input bit poke);
        int  waited;
        bit  seen;
        fault_kind = kind;
        fault_a    = fa;
        fault_b    = fb;
        @(negedge clk);
        mem_size = (AW+1)'(size);
        clr_cnt  = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", longint'(busy), 1);
        check("R10", "fail cleared by start", longint'(fail), 0);
        waited = 0;
        seen   = 1'b0;
        while (!seen && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 40) start = 1'b1;
            if (poke && waited == 41) start = 1'b0;
            if (done) seen = 1'b1;
        end
        start = 1'b0;
        if (!seen) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s watchdog: actual no done expected done", req);
            return;
        end
        check(req, "fail flag", longint'(fail), longint'(exp_fail));
        check(req, "fail address", longint'(fail_addr), exp_addr);
        check("R9", "busy low with done", longint'(busy), 0);
        if (exp_count >= 0) check(req, "accepted requests", n_acc, exp_count);
        check("R8", "request during outstanding read", viol, 0);
        @(negedge clk);
        check("R9", "done width", longint'(done), 0);
        repeat (20) @(negedge clk);
        check("R10", "fail held", longint'(fail), longint'(exp_fail));
        check("R10", "fail address held", longint'(fail_addr), exp_addr);
        check("R10", "no second run", longint'(busy), 0);
    endtask

    initial begin
        rst       = 1'b1;
        start     = 1'b0;
        base_addr = BASE;
        mem_size  = (AW+1)'(4096);
        repeat (4) @(negedge clk);
        check("R1", "busy in reset", longint'(busy), 0);
        check("R1", "done in reset", longint'(done), 0);
        check("R1", "fail in reset", longint'(fail), 0);
        check("R1", "fail_addr in reset", longint'(fail_addr), 0);
        check("R1", "request in reset", longint'(mem_req_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "no request while idle", longint'(mem_req_valid), 0);

        // R7 R9: full clean pass, N=10 offsets
        run_case("R7", 4096, 0, 0, 0, 1'b0, 0, 206, 1'b0);
        check("R2", "first request is write", longint'(first_we), 1);
        check("R2", "first request address", longint'(first_addr), longint'(BASE));
        check("R2", "first request data", longint'(first_wdata), 1);

        // R4: no offset visited at size 4
        run_case("R4", 4, 0, 0, 0, 1'b0, 0, 66, 1'b0);
        // R4: stuck line above the window is not seen, N=4
        run_case("R4", 64, 1, 5, 0, 1'b0, 0, 98, 1'b0);
        // R3: data line 5 stuck low, six write/read pairs
        run_case("R3", 4096, 4, 5, 0, 1'b1, int'(BASE), 12, 1'b0);
        // R5: address line (byte 0x20) stuck high
        run_case("R5", 4096, 1, 3, 0, 1'b1, int'(BASE) + 32'h20, -1, 1'b0);
        // R5: address line (byte 0x40) stuck low
        run_case("R5", 4096, 2, 4, 0, 1'b1, int'(BASE) + 32'h40, -1, 1'b0);
        // R6: lines for 0x10 and 0x80 shorted
        run_case("R6", 4096, 3, 2, 5, 1'b1, int'(BASE) + 32'h80, -1, 1'b0);
        // R10: start pulsed mid-run is ignored
        run_case("R10", 4096, 0, 0, 0, 1'b0, 0, 206, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule